// File: doc/BRIEF.md
# Pixel Colour Key Generator

This block produces a one-bit key for each pixel. A downstream analog mixer uses the key to choose between the converter's own video output and an external analog RGB source. The key can come straight from an external key input, or it can be derived by comparing the bytes of the incoming pixel with a programmed 8-bit key value. The comparison can cover one, two or three bytes of the pixel.

The key passes through a delay line that adds between 0 and 7 pixel clocks, so that it can be lined up with the video path. It then passes through a polarity control, which decides whether a high key selects the converter output or the external source. A register interface writes all control fields in one strobed load. Reset clears every field, which leaves the block in external-key mode with keying disabled, no added delay and normal polarity.

Top module: `pix_key_gen`

## Requirements
- R1: After reset all control fields are zero, so `keyOut` is 0 and stays 0 whatever `extKey` and `pixData` do, until a load. A load (`cfgLoad`=1 at a rising edge) captures every control field at that edge. The captured values govern the comparison made at that same edge only from the following edge onward, while the new delay and polarity act on `keyOut` right after the load edge.
- R2: With mode 3'b000 and keying enabled, the undelayed key equals `extKey`.
- R3: With mode 3'b100, the key is 1 when lane 0 (`pixData[7:0]`) equals `cfgKeyVal`.
- R4: With mode 3'b110, the key is 1 when lane 0 and lane 1 (`pixData[15:8]`) both equal `cfgKeyVal`.
- R5: With mode 3'b111, the key is 1 when lanes 0, 1 and 2 (`pixData[23:16]`) all equal `cfgKeyVal`.
- R6: With mode 3'b101, the key is 1 only when `pixPairValid` is 1 and lanes 0 and 1 both equal `cfgKeyVal`.
- R7: The reserved mode codes (3'b001, 3'b010, 3'b011) force the key to its inactive level, 0 before polarity.
- R8: With `cfgEnable`=0, the key is forced inactive in every mode.
- R9: Pixel and key inputs sampled at rising edge t appear on `keyOut` just after edge t+D, where D is the delay field (0 to 7). This is one registered stage plus D further stages.
- R10: With the polarity bit at 1, `keyOut` is the inverse of the delayed key. With it at 0, `keyOut` is the delayed key unchanged.
- R11: Changing the delay field moves the output tap at the load edge, with no reset. The history already held in the delay line is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgLoad | input | 1 | Load strobe for the control fields |
| cfgMode | input | 3 | Keying mode code |
| cfgDelay | input | 3 | Added key delay in pixel clocks |
| cfgInvert | input | 1 | Key polarity |
| cfgEnable | input | 1 | Keying enable |
| cfgKeyVal | input | 8 | Key byte compared with each pixel lane |
| pixData | input | 24 | Pixel bytes, lane 0 in bits 7:0 |
| pixPairValid | input | 1 | Pair strobe for the two-edge-latched mode |
| extKey | input | 1 | External key input |
| keyOut | output | 1 | Key to the analog mixer |

## Verification
The bench builds the block with its defaults: 8-bit lanes, three lanes and an eight-stage line. At this size every combination of the 3-bit mode, the enable, the polarity and the 3-bit delay is small enough to sweep in full, including every reserved code and every tap. Each combination is loaded without a reset and then run with pixel bytes biased toward the key value, so that matches and single-bit misses both occur in every lane. Because the line keeps running across loads, the same sweep also shows the tap switching over history written under the previous setting.

// File: rtl/pix_key_pkg.sv
package pix_key_pkg;
  localparam int KEY_LANES = 3;

  typedef enum logic [2:0] {
    KM_EXT   = 3'b000,
    KM_ONE   = 3'b100,
    KM_PAIR  = 3'b101,
    KM_TWO   = 3'b110,
    KM_THREE = 3'b111
  } keyMode_e;

  typedef struct packed {
    logic useExt;
    logic cmpOne;
    logic cmpTwo;
    logic cmpThree;
    logic needPair;
    logic invert;
  } keyStrobe_t;
endpackage

// File: rtl/pix_key_ctrl.sv
module pix_key_ctrl
  import pix_key_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int TAP_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic [2:0]        cfgMode,
  input  logic [TAP_W-1:0]  cfgDelay,
  input  logic              cfgInvert,
  input  logic              cfgEnable,
  input  logic [BYTE_W-1:0] cfgKeyVal,
  output keyStrobe_t        strb,
  output logic [TAP_W-1:0]  tapSel,
  output logic [BYTE_W-1:0] keyVal
);
  logic [2:0] modeQ;
  logic       invQ;
  logic       enQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= '0;
      tapSel <= '0;
      invQ   <= 1'b0;
      enQ    <= 1'b0;
      keyVal <= '0;
    end else if (cfgLoad) begin
      modeQ  <= cfgMode;
      tapSel <= cfgDelay;
      invQ   <= cfgInvert;
      enQ    <= cfgEnable;
      keyVal <= cfgKeyVal;
    end
  end

  always_comb begin
    strb        = '0;
    strb.invert = invQ;
    if (enQ) begin
      case (modeQ)
        KM_EXT:   strb.useExt = 1'b1;
        KM_ONE:   strb.cmpOne = 1'b1;
        KM_PAIR: begin
          strb.cmpTwo   = 1'b1;
          strb.needPair = 1'b1;
        end
        KM_TWO:   strb.cmpTwo = 1'b1;
        KM_THREE: strb.cmpThree = 1'b1;
        default:  ;
      endcase
    end
  end

  // R1: a load captures the mode field on its edge
  p_load_capture_r1: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoad |=> (modeQ == $past(cfgMode)));

  // R7: at most one key source is ever selected
  p_one_source_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.useExt, strb.cmpOne, strb.cmpTwo, strb.cmpThree}));
endmodule

// File: rtl/pix_key_path.sv
module pix_key_path
  import pix_key_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int STAGES = 8,
  parameter int TAP_W  = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [KEY_LANES*BYTE_W-1:0] pixData,
  input  logic                        pixPairValid,
  input  logic                        extKey,
  input  keyStrobe_t                  strb,
  input  logic [TAP_W-1:0]            tapSel,
  input  logic [BYTE_W-1:0]           keyVal,
  output logic                        keyOut
);
  logic [KEY_LANES-1:0] laneEq;
  logic                 rawKey;
  logic [STAGES-1:0]    line;

  for (genvar g = 0; g < KEY_LANES; g++) begin : g_lane
    assign laneEq[g] = (pixData[g*BYTE_W +: BYTE_W] == keyVal);
  end

  always_comb begin
    rawKey = 1'b0;
    if (strb.useExt)        rawKey = extKey;
    else if (strb.cmpOne)   rawKey = laneEq[0];
    else if (strb.cmpTwo)   rawKey = laneEq[0] & laneEq[1] & (~strb.needPair | pixPairValid);
    else if (strb.cmpThree) rawKey = &laneEq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) line[0] <= 1'b0;
    else       line[0] <= rawKey;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) line[s] <= 1'b0;
      else       line[s] <= line[s-1];
    end
  end

  assign keyOut = line[tapSel] ^ strb.invert;

  // R2: the external key reaches the first stage one edge later
  p_ext_follow_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.useExt |=> (line[0] == $past(extKey)));

  // R6: no pair strobe, no key in the pair mode
  p_pair_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.needPair && !pixPairValid) |=> !line[0]);

  // R9: the last stage follows the one before it
  p_stage_shift_r9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (line[STAGES-1] == $past(line[STAGES-2])));
endmodule

// File: rtl/pix_key_gen.sv
module pix_key_gen
  import pix_key_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int STAGES = 8,
  localparam int TAP_W = $clog2(STAGES),
  localparam int PIX_W = KEY_LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic [2:0]        cfgMode,
  input  logic [TAP_W-1:0]  cfgDelay,
  input  logic              cfgInvert,
  input  logic              cfgEnable,
  input  logic [BYTE_W-1:0] cfgKeyVal,
  input  logic [PIX_W-1:0]  pixData,
  input  logic              pixPairValid,
  input  logic              extKey,
  output logic              keyOut
);
  keyStrobe_t        strb;
  logic [TAP_W-1:0]  tapSel;
  logic [BYTE_W-1:0] keyVal;

  pix_key_ctrl #(.BYTE_W(BYTE_W), .TAP_W(TAP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgMode(cfgMode),
    .cfgDelay(cfgDelay), .cfgInvert(cfgInvert), .cfgEnable(cfgEnable),
    .cfgKeyVal(cfgKeyVal), .strb(strb), .tapSel(tapSel), .keyVal(keyVal)
  );

  pix_key_path #(.BYTE_W(BYTE_W), .STAGES(STAGES), .TAP_W(TAP_W)) u_path (
    .clk(clk), .rstN(rstN), .pixData(pixData), .pixPairValid(pixPairValid),
    .extKey(extKey), .strb(strb), .tapSel(tapSel), .keyVal(keyVal),
    .keyOut(keyOut)
  );
endmodule

// File: tb/pix_key_gen_bench.sv
module pix_key_gen_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgLoad = 1'b0;
  logic [2:0]  cfgMode = '0;
  logic [2:0]  cfgDelay = '0;
  logic        cfgInvert = 1'b0;
  logic        cfgEnable = 1'b0;
  logic [7:0]  cfgKeyVal = '0;
  logic [23:0] pixData = '0;
  logic        pixPairValid = 1'b0;
  logic        extKey = 1'b0;
  logic        keyOut;

  int errors = 0;
  int checks = 0;

  logic [2:0] mMode = '0;
  logic [2:0] mDelay = '0;
  logic       mInv = 1'b0;
  logic       mEn = 1'b0;
  logic [7:0] mKey = '0;
  logic [7:0] hist = '0;

  always #5 clk = ~clk;

  pix_key_gen u_pix_key_gen (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgMode(cfgMode),
    .cfgDelay(cfgDelay), .cfgInvert(cfgInvert), .cfgEnable(cfgEnable),
    .cfgKeyVal(cfgKeyVal), .pixData(pixData), .pixPairValid(pixPairValid),
    .extKey(extKey), .keyOut(keyOut)
  );

  function automatic logic expRaw(input logic [23:0] px, input logic pv, input logic ek);
    logic b0, b1, b2;
    b0 = (px[7:0] == mKey);
    b1 = (px[15:8] == mKey);
    b2 = (px[23:16] == mKey);
    if (!mEn) return 1'b0;
    case (mMode)
      3'b000:  return ek;
      3'b100:  return b0;
      3'b101:  return pv & b0 & b1;
      3'b110:  return b0 & b1;
      3'b111:  return b0 & b1 & b2;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tagNow(input bit firstAfterLoad);
    string t;
    if (firstAfterLoad) t = "R11";
    else if (!mEn) t = "R8";
    else case (mMode)
      3'b000:  t = "R2";
      3'b100:  t = "R3";
      3'b110:  t = "R4";
      3'b111:  t = "R5";
      3'b101:  t = "R6";
      default: t = "R7";
    endcase
    if (mDelay != 0) t = {t, "/R9"};
    if (mInv) t = {t, "/R10"};
    return t;
  endfunction

  function automatic logic [7:0] laneByte(input logic [7:0] k);
    if ($urandom_range(2) != 0) return k;
    return k ^ (8'h01 << $urandom_range(7));
  endfunction

  task automatic check(input logic exp, input string tag);
    checks++;
    if (keyOut !== exp) begin
      errors++;
      $display("FAIL %s: keyOut=%b expected=%b (mode=%b en=%b inv=%b dly=%0d)",
               tag, keyOut, exp, mMode, mEn, mInv, mDelay);
    end
  endtask

  task automatic cycle(input logic load, input logic [2:0] m, input logic [2:0] d,
                       input logic inv, input logic en, input logic [7:0] kv,
                       input logic [23:0] px, input logic pv, input logic ek,
                       input string forceTag);
    logic raw;
    @(negedge clk);
    cfgLoad = load; cfgMode = m; cfgDelay = d; cfgInvert = inv;
    cfgEnable = en; cfgKeyVal = kv; pixData = px; pixPairValid = pv; extKey = ek;
    @(posedge clk);
    raw  = expRaw(px, pv, ek);
    hist = {hist[6:0], raw};
    if (load) begin
      mMode = m; mDelay = d; mInv = inv; mEn = en; mKey = kv;
    end
    #1;
    check(hist[mDelay] ^ mInv, (forceTag != "") ? forceTag : tagNow(load));
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(1'b0, "R1");
    @(negedge clk) rstN = 1'b1;
    // R1: reset state is disabled external mode, so the key stays low
    for (int i = 0; i < 8; i++)
      cycle(1'b0, 3'b111, 3'd5, 1'b1, 1'b1, 8'hFF, 24'h0, 1'b1, i[0], "R1");
    // full sweep of mode, enable, polarity and delay without reset
    for (int m = 0; m < 8; m++)
      for (int e = 0; e < 2; e++)
        for (int v = 0; v < 2; v++)
          for (int d = 0; d < 8; d++) begin
            logic [7:0] kv;
            kv = 8'($urandom);
            cycle(1'b1, 3'(m), 3'(d), v[0], e[0], kv,
                  {laneByte(kv), laneByte(kv), laneByte(kv)},
                  1'($urandom), 1'($urandom), "");
            for (int c = 0; c < 10; c++)
              cycle(1'b0, 3'($urandom), 3'($urandom), 1'($urandom), 1'($urandom), 8'($urandom),
                    {laneByte(kv), laneByte(kv), laneByte(kv)},
                    1'($urandom), 1'($urandom), "");
          end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule